// File: doc/BRIEF.md
# Serial Debug Command Controller

This block lets a host on a serial link control a small 12-bit accumulator processor and look at its state. It sits between a byte-wide serial receiver/transmitter and the core. Each received byte is read as a single-letter command. Some letters drive the core's reset and clock-enable, which lets the host halt the core, resume it, step one instruction at a time or restart it. Other letters ask for the accumulator or the program counter.

A query captures the chosen register at once. The block then sends the value back as a short text line: uppercase hexadecimal digits, most significant digit first, followed by carriage return and line feed. Each byte goes out through a valid/ready handshake. While a reply line is being sent, every incoming byte is discarded. This keeps the command stream and the replies in a simple one-to-one order.

Top module: `dbg_cmd_ctrl`

## Requirements
- R1: After the synchronous reset, `core_en`, `core_rst` and `tx_valid` are all low, so the core comes up halted.
- R2: The byte 0x72 ('r') makes `core_rst` high for exactly one clock, starting on the edge that samples `rx_valid`, and leaves `core_en` low.
- R3: The byte 0x73 ('s') clears `core_en` on the sampling edge, and it stays low while no further command arrives.
- R4: The byte 0x65 ('e') sets `core_en` on the sampling edge, and it stays high while no further command arrives.
- R5: The byte 0x6B ('k') received while halted raises `core_en` for exactly one clock. Received while running, it has no effect.
- R6: The byte 0x61 ('a') starts a reply of DATA_W/4 digits (rounded up) of the accumulator, then 0x0D and 0x0A. The digits are in ASCII uppercase hex ('0'-'9' = 0x30-0x39, 'A'-'F' = 0x41-0x46), most significant nibble first. `tx_valid` rises on the sampling edge.
- R7: The byte 0x70 ('p') starts the same reply format carrying the program counter.
- R8: The value sent is the one present on the sampling edge. Later changes of `acc_in` or `pc_in` do not alter the reply.
- R9: `tx_byte` and `tx_valid` hold steady until `tx_ready` is high on an edge. The next byte then appears. After the line feed is accepted, `tx_valid` drops.
- R10: Any byte outside the six command codes (including uppercase letters) changes none of the outputs.
- R11: Any byte received while `tx_valid` is high is dropped. This includes control commands, which then leave `core_en` and `core_rst` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One-cycle strobe: a received byte is present |
| rx_byte | input | 8 | Received byte |
| tx_ready | input | 1 | Transmitter accepts the presented byte |
| acc_in | input | DATA_W | Core accumulator value |
| pc_in | input | DATA_W | Core program counter value |
| core_rst | output | 1 | One-clock reset pulse to the core |
| core_en | output | 1 | Clock enable for the core |
| tx_byte | output | 8 | Byte to transmit |
| tx_valid | output | 1 | `tx_byte` is valid |

## Verification
The bench builds the block with DATA_W = 12, so each reply has three digits and is five bytes long. With this width the bench can send the all-zero and all-ones values and mixed values that contain every digit class, including the 9-to-A boundary of the hex conversion. It also holds `tx_ready` low for different stall lengths to check the hold rule, and it injects commands during a reply to check that they are dropped.

// File: rtl/dbg_pkg.sv
package dbg_pkg;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_RESET,
    CMD_HALT,
    CMD_RUN,
    CMD_STEP,
    CMD_RD_ACC,
    CMD_RD_PC
  } cmd_e;

  localparam logic [7:0] CH_RESET = 8'h72;
  localparam logic [7:0] CH_HALT  = 8'h73;
  localparam logic [7:0] CH_RUN   = 8'h65;
  localparam logic [7:0] CH_STEP  = 8'h6B;
  localparam logic [7:0] CH_ACC   = 8'h61;
  localparam logic [7:0] CH_PC    = 8'h70;
  localparam logic [7:0] CH_CR    = 8'h0D;
  localparam logic [7:0] CH_LF    = 8'h0A;

  function automatic logic [7:0] nib_to_ascii(input logic [3:0] n);
    if (n < 4'd10) return 8'h30 + {4'h0, n};
    else           return 8'h37 + {4'h0, n};
  endfunction

endpackage

// File: rtl/dbg_decode.sv
module dbg_decode
  import dbg_pkg::*;
(
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  input  logic       busy,
  output logic       cmd_ok,
  output cmd_e       cmd
);

  always_comb begin
    case (rx_byte)
      CH_RESET: cmd = CMD_RESET;
      CH_HALT:  cmd = CMD_HALT;
      CH_RUN:   cmd = CMD_RUN;
      CH_STEP:  cmd = CMD_STEP;
      CH_ACC:   cmd = CMD_RD_ACC;
      CH_PC:    cmd = CMD_RD_PC;
      default:  cmd = CMD_NONE;
    endcase
  end

  // R10, R11: unknown codes and bytes arriving mid-reply are never accepted
  assign cmd_ok = rx_valid && !busy && (cmd != CMD_NONE);

endmodule

// File: rtl/dbg_run_ctl.sv
module dbg_run_ctl
  import dbg_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cmd_ok,
  input  cmd_e cmd,
  output logic core_rst,
  output logic core_en
);

  logic run_q;
  logic step_q;
  logic rst_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      step_q <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      rst_q  <= 1'b0;
      step_q <= 1'b0;
      if (cmd_ok) begin
        case (cmd)
          CMD_RESET: begin
            rst_q <= 1'b1;
            run_q <= 1'b0;
          end
          CMD_HALT: run_q <= 1'b0;
          CMD_RUN:  run_q <= 1'b1;
          CMD_STEP: if (!run_q) step_q <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  assign core_rst = rst_q;
  assign core_en  = run_q | step_q;

  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    core_rst |=> !core_rst);  // R2
  AST_RST_HALTED: assert property (@(posedge clk) disable iff (rst)
    core_rst |-> !core_en);  // R2
  AST_STEP_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (step_q && !(cmd_ok && cmd == CMD_STEP)) |=> !step_q);  // R5
  AST_STEP_ONLY_HALTED: assert property (@(posedge clk) disable iff (rst)
    step_q |-> !run_q);  // R5

endmodule

// File: rtl/dbg_reply.sv
module dbg_reply
  import dbg_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_ok,
  input  cmd_e              cmd,
  input  logic [DATA_W-1:0] acc_in,
  input  logic [DATA_W-1:0] pc_in,
  input  logic              tx_ready,
  output logic [7:0]        tx_byte,
  output logic              tx_valid
);

  localparam int NIB     = (DATA_W + 3) / 4;
  localparam int PAD_W   = NIB * 4;
  localparam int MSG_LEN = NIB + 2;
  localparam int IDX_W   = $clog2(MSG_LEN + 1);

  logic [PAD_W-1:0] hold_q;
  logic [IDX_W-1:0] idx_q;
  logic [7:0]       byte_q;
  logic             valid_q;
  logic [PAD_W-1:0] pick_pad;
  logic             start;

  function automatic logic [7:0] msg_char(input logic [PAD_W-1:0] v,
                                          input int unsigned pos);
    logic [3:0] n;
    if (pos < NIB) begin
      n = v[(NIB - 1 - pos) * 4 +: 4];
      return nib_to_ascii(n);
    end else if (pos == NIB) begin
      return CH_CR;
    end else begin
      return CH_LF;
    end
  endfunction

  assign start = cmd_ok && (cmd == CMD_RD_ACC || cmd == CMD_RD_PC);

  always_comb begin
    pick_pad = '0;
    pick_pad[DATA_W-1:0] = (cmd == CMD_RD_PC) ? pc_in : acc_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q  <= '0;
      idx_q   <= '0;
      byte_q  <= '0;
      valid_q <= 1'b0;
    end else if (!valid_q) begin
      if (start) begin
        hold_q  <= pick_pad;
        idx_q   <= '0;
        byte_q  <= msg_char(pick_pad, 0);
        valid_q <= 1'b1;
      end
    end else if (tx_ready) begin
      if (idx_q == IDX_W'(MSG_LEN - 1)) begin
        valid_q <= 1'b0;
        idx_q   <= '0;
      end else begin
        idx_q  <= idx_q + 1'b1;
        byte_q <= msg_char(hold_q, int'(idx_q) + 1);
      end
    end
  end

  assign tx_byte  = byte_q;
  assign tx_valid = valid_q;

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte)));  // R9
  AST_TX_LEGAL_CHAR: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> ((tx_byte >= 8'h30 && tx_byte <= 8'h39) ||
                  (tx_byte >= 8'h41 && tx_byte <= 8'h46) ||
                  tx_byte == CH_CR || tx_byte == CH_LF));  // R6
  AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && $past(tx_valid)) |-> $stable(hold_q));  // R8

endmodule

// File: rtl/dbg_cmd_ctrl.sv
module dbg_cmd_ctrl
  import dbg_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  input  logic              tx_ready,
  input  logic [DATA_W-1:0] acc_in,
  input  logic [DATA_W-1:0] pc_in,
  output logic              core_rst,
  output logic              core_en,
  output logic [7:0]        tx_byte,
  output logic              tx_valid
);

  logic cmd_ok;
  cmd_e cmd;

  dbg_decode u_dec (
    .rx_valid (rx_valid),
    .rx_byte  (rx_byte),
    .busy     (tx_valid),
    .cmd_ok   (cmd_ok),
    .cmd      (cmd)
  );

  dbg_run_ctl u_run (
    .clk      (clk),
    .rst      (rst),
    .cmd_ok   (cmd_ok),
    .cmd      (cmd),
    .core_rst (core_rst),
    .core_en  (core_en)
  );

  dbg_reply #(.DATA_W(DATA_W)) u_reply (
    .clk      (clk),
    .rst      (rst),
    .cmd_ok   (cmd_ok),
    .cmd      (cmd),
    .acc_in   (acc_in),
    .pc_in    (pc_in),
    .tx_ready (tx_ready),
    .tx_byte  (tx_byte),
    .tx_valid (tx_valid)
  );

  AST_BUSY_DROPS_CTRL: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && rx_valid) |=> ($stable(core_en) && !core_rst));  // R11
  AST_RESET_CLEAN: assert property (@(posedge clk)
    rst |=> (!core_en && !core_rst && !tx_valid));  // R1

endmodule

// File: tb/sim_dbg_cmd_ctrl.sv
module sim_dbg_cmd_ctrl;

  localparam int DW = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rx_valid = 1'b0;
  logic [7:0]    rx_byte = 8'h00;
  logic          tx_ready = 1'b0;
  logic [DW-1:0] acc_in = '0;
  logic [DW-1:0] pc_in = '0;
  logic          core_rst, core_en, tx_valid;
  logic [7:0]    tx_byte;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dbg_cmd_ctrl #(.DATA_W(DW)) u0 (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .tx_ready(tx_ready), .acc_in(acc_in), .pc_in(pc_in),
    .core_rst(core_rst), .core_en(core_en), .tx_byte(tx_byte),
    .tx_valid(tx_valid)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000 && !done) begin
      failures = failures + 1;
      $display("FAIL watchdog expired act=%0d exp=<50000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      failures = failures + 1;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_char(input logic [DW-1:0] v, input int pos);
    logic [3:0] d;
    if (pos == 3) return 8'h0D;
    if (pos == 4) return 8'h0A;
    d = v[11 - 4*pos -: 4];
    case (d)
      4'hA: return "A";
      4'hB: return "B";
      4'hC: return "C";
      4'hD: return "D";
      4'hE: return "E";
      4'hF: return "F";
      default: return 8'd48 + d;
    endcase
  endfunction

  task automatic send_cmd(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_byte  = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic read_reply(input logic [DW-1:0] v, input int stall,
                            input string req);
    for (int i = 0; i < 5; i++) begin
      for (int s = 0; s < stall; s++) begin
        check({req, " R9 held valid"}, tx_valid, 1'b1);
        check({req, " R9 held byte"}, tx_byte, exp_char(v, i));
        @(negedge clk);
      end
      check({req, " valid"}, tx_valid, 1'b1);
      check({req, " byte"}, tx_byte, exp_char(v, i));
      tx_ready = 1'b1;
      @(negedge clk);
      tx_ready = 1'b0;
    end
    check({req, " R9 valid drops after LF"}, tx_valid, 1'b0);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 core_en", core_en, 1'b0);
    check("R1 core_rst", core_rst, 1'b0);
    check("R1 tx_valid", tx_valid, 1'b0);
  endtask

  task automatic t_run_halt;
    send_cmd(8'h65);
    check("R4 run", core_en, 1'b1);
    repeat (5) @(negedge clk);
    check("R4 stays running", core_en, 1'b1);
    send_cmd(8'h73);
    check("R3 halt", core_en, 1'b0);
    repeat (5) @(negedge clk);
    check("R3 stays halted", core_en, 1'b0);
  endtask

  task automatic t_step;
    send_cmd(8'h6B);
    check("R5 step high", core_en, 1'b1);
    @(negedge clk);
    check("R5 step one cycle", core_en, 1'b0);
    repeat (3) @(negedge clk);
    check("R5 halted after step", core_en, 1'b0);
    send_cmd(8'h65);
    send_cmd(8'h6B);
    check("R5 step while running", core_en, 1'b1);
    repeat (3) @(negedge clk);
    check("R5 still running", core_en, 1'b1);
  endtask

  task automatic t_reset_cmd;
    send_cmd(8'h72);
    check("R2 pulse", core_rst, 1'b1);
    check("R2 halted", core_en, 1'b0);
    @(negedge clk);
    check("R2 pulse ends", core_rst, 1'b0);
    check("R2 stays halted", core_en, 1'b0);
  endtask

  task automatic t_query;
    acc_in = 12'hA5F;
    send_cmd(8'h61);
    read_reply(12'hA5F, 0, "R6 acc A5F");
    acc_in = 12'h000;
    send_cmd(8'h61);
    read_reply(12'h000, 2, "R6 acc 000");
    pc_in = 12'hFFF;
    send_cmd(8'h70);
    read_reply(12'hFFF, 1, "R7 pc FFF");
    pc_in = 12'h9A0;
    send_cmd(8'h70);
    read_reply(12'h9A0, 3, "R7 pc 9A0");
  endtask

  task automatic t_capture;
    acc_in = 12'h3C7;
    send_cmd(8'h61);
    acc_in = 12'hB12;
    read_reply(12'h3C7, 1, "R8 acc capture");
    pc_in = 12'h8E4;
    send_cmd(8'h70);
    pc_in = 12'h000;
    read_reply(12'h8E4, 0, "R8 pc capture");
  endtask

  task automatic t_ignore;
    logic [7:0] bad [4] = '{8'h78, 8'h52, 8'h41, 8'h00};
    send_cmd(8'h65);
    for (int i = 0; i < 4; i++) begin
      send_cmd(bad[i]);
      check("R10 en kept", core_en, 1'b1);
      check("R10 no reset", core_rst, 1'b0);
      check("R10 no reply", tx_valid, 1'b0);
    end
    send_cmd(8'h73);
    send_cmd(8'h4B);
    check("R10 uppercase K no step", core_en, 1'b0);
  endtask

  task automatic t_busy_drop;
    acc_in = 12'h5D2;
    send_cmd(8'h61);
    send_cmd(8'h65);
    check("R11 run dropped", core_en, 1'b0);
    pc_in = 12'h111;
    send_cmd(8'h70);
    send_cmd(8'h72);
    check("R11 reset dropped", core_rst, 1'b0);
    read_reply(12'h5D2, 0, "R11 reply intact");
    repeat (2) @(negedge clk);
    check("R11 no second reply", tx_valid, 1'b0);
  endtask

  initial begin
    t_reset;
    t_run_halt;
    t_step;
    t_reset_cmd;
    t_query;
    t_capture;
    t_ignore;
    t_busy_drop;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule